// File: doc/BRIEF.md
# Scanline Start Address Generator

This block works out, for each displayed scanline of a frame, the byte address in video memory where that scanline's pixel data begins. A frame pulse loads the programmed configuration into shadow registers. It sets the running base address to four times the programmed start value and clears the row counter. After that, each line pulse moves the generator one scanline down the frame.

The base address does not move on every scanline. A repeat counter holds a line for a programmed number of extra scans. The base then adds the line pitch, but only on row-counter values picked out by a mask. For interleaved legacy layouts, the low row-counter bits can be written into address bit 14 or 15.

When the line number matches a programmed split value, the base address restarts at zero for the rest of the frame. The block also reports a display mode (blank, text or graphics) and a pixel-width doubling flag. Both are taken from the configuration sampled at the frame pulse.

The sequencer has two states. IDLE holds after reset. Line pulses are ignored in IDLE, and the frame pulse moves it to SCAN. In SCAN, a line pulse advances one scanline and the state stays SCAN. A frame pulse in SCAN restarts the frame and the state stays SCAN.

Top module: `ladr_gen`

## Requirements
- R1: After reset, line_addr is 0, line_num is 0, disp_mode is blank (2'b10) and wide_out is 0. Line pulses that arrive before the first frame pulse change none of these outputs.
- R2: One clock after a frame pulse, line_num is 0 and line_addr is cfg_start*4, with the row bits of R6 and R7 applied for row 0.
- R3: Outside shift mode 1, each line address is held for ((cfg_scan_max+1) << cfg_dbl) scanlines before the base address moves.
- R4: In shift mode 1 (cfg_shift == 2'b01), cfg_scan_max is ignored and each line address is held for cfg_dbl+1 scanlines.
- R5: When the repeat counter expires, the row counter increments. The base adds cfg_pitch only if (row & m) == m, where m = {~cfg_keep_hi, ~cfg_keep_lo} and row is the value before the increment.
- R6: When cfg_keep_lo is 0, row bit 0 replaces address bit 14, or bit 15 if cfg_lo_sel is 1.
- R7: When cfg_keep_hi is 0, row bit 1 replaces address bit 15. This takes priority over R6.
- R8: When line number N equals cfg_split, the base address is 0 for line N+1, and later lines advance from 0.
- R9: disp_mode is 2'b10 (blank) when cfg_vid_en is 0. Otherwise it is 2'b01 (graphics) when cfg_gfx is 1, and 2'b00 (text) when cfg_gfx is 0.
- R10: wide_out is 1 only when cfg_half_dot is 1 and cfg_shift is 2'b00 or 2'b01.
- R11: Configuration inputs are sampled only at the frame pulse. Changes in the middle of a frame do not affect line_addr, disp_mode or wide_out until the next frame pulse.
- R12: line_addr and line_num are registered. They change only one clock after a frame pulse or a line pulse, and line_num then counts up by one per line pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_go | input | 1 | Frame start pulse |
| line_step | input | 1 | Advance to next scanline |
| cfg_start | input | START_W | Frame start address in units of 4 bytes |
| cfg_pitch | input | PITCH_W | Bytes added per address row |
| cfg_split | input | LINE_W | Line number after which the base restarts at 0 |
| cfg_scan_max | input | 5 | Scans per row minus one |
| cfg_dbl | input | 1 | Doubles the scans per row |
| cfg_shift | input | 2 | Shift mode; 2'b01 selects the legacy repeat rule |
| cfg_keep_lo | input | 1 | 0 writes row bit 0 into address bit 14 or 15 |
| cfg_keep_hi | input | 1 | 0 writes row bit 1 into address bit 15 |
| cfg_lo_sel | input | 1 | Selects bit 15 (1) or bit 14 (0) for row bit 0 |
| cfg_vid_en | input | 1 | Video enable; 0 gives blank mode |
| cfg_gfx | input | 1 | Graphics (1) or text (0) |
| cfg_half_dot | input | 1 | Requests doubled pixel width |
| line_addr | output | START_W+2 | Start byte address of the current scanline |
| line_num | output | LINE_W | Current displayed line number |
| disp_mode | output | 2 | 00 text, 01 graphics, 10 blank |
| wide_out | output | 1 | Pixel-width doubling flag |

## Verification
The bench targets three places where errors are likely.

- Repeat count: tests use a 5-bit scan maximum with doubling, and shift mode 1 with a non-zero scan maximum. An off-by-one or a missed mode-1 override would move the address on the wrong scanline.
- Interleaved layouts: tests run with both keep bits clear and with each one alone. Addresses that fail to step only on masked rows, or a bit 15 that row bit 0 takes from row bit 1, show up as wrong high address bits.
- Split and mid-frame changes: the split test checks that the base drops to 0 on exactly the line after the match. A mid-frame change test checks that a block reading live inputs instead of its frame snapshot is caught.

// File: rtl/ladr_pkg.sv
package ladr_pkg;

    typedef enum logic [1:0] {
        MODE_TEXT  = 2'b00,
        MODE_GFX   = 2'b01,
        MODE_BLANK = 2'b10
    } disp_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [4:0] scan_max;
        logic       dbl;
        logic [1:0] shift;
        logic       keep_lo;
        logic       keep_hi;
        logic       lo_sel;
        logic       vid_en;
        logic       gfx;
        logic       half_dot;
    } mode_cfg_t;

    localparam int RPT_W = 6;

    // Scans per row minus one, derived from the scan field and doubling bit.
    function automatic logic [RPT_W-1:0] rpt_count(input logic [1:0] shift,
                                                    input logic [4:0] smax,
                                                    input logic       dbl);
        logic [RPT_W:0] t;
        if (shift == 2'b01) begin
            return {{(RPT_W-1){1'b0}}, dbl};
        end
        t = {2'b00, smax} + 7'd1;
        if (dbl) t = {t[RPT_W-1:0], 1'b0};
        t = t - 7'd1;
        return t[RPT_W-1:0];
    endfunction

endpackage

// File: rtl/ladr_cfg_latch.sv
module ladr_cfg_latch
    import ladr_pkg::*;
#(
    parameter int START_W = 16,
    parameter int PITCH_W = 12,
    parameter int LINE_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_go,
    input  mode_cfg_t          raw_cfg,
    input  logic [START_W-1:0] raw_start,
    input  logic [PITCH_W-1:0] raw_pitch,
    input  logic [LINE_W-1:0]  raw_split,
    output mode_cfg_t          eff_cfg,
    output logic [START_W-1:0] eff_start,
    output logic [PITCH_W-1:0] eff_pitch,
    output logic [LINE_W-1:0]  eff_split,
    output logic [RPT_W-1:0]   eff_cnt,
    output logic [1:0]         eff_mask,
    output logic [1:0]         disp_mode,
    output logic               wide
);

    mode_cfg_t          sh_cfg;
    logic [START_W-1:0] sh_start;
    logic [PITCH_W-1:0] sh_pitch;
    logic [LINE_W-1:0]  sh_split;
    disp_mode_e         mode_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cfg   <= '0;
            sh_start <= '0;
            sh_pitch <= '0;
            sh_split <= '0;
        end else if (frame_go) begin
            sh_cfg   <= raw_cfg;
            sh_start <= raw_start;
            sh_pitch <= raw_pitch;
            sh_split <= raw_split;
        end
    end

    // The frame pulse cycle sees the incoming values; all later cycles see the snapshot.
    always_comb begin
        eff_cfg   = frame_go ? raw_cfg   : sh_cfg;
        eff_start = frame_go ? raw_start : sh_start;
        eff_pitch = frame_go ? raw_pitch : sh_pitch;
        eff_split = frame_go ? raw_split : sh_split;
        eff_cnt   = rpt_count(eff_cfg.shift, eff_cfg.scan_max, eff_cfg.dbl);
        eff_mask  = {~eff_cfg.keep_hi, ~eff_cfg.keep_lo};
    end

    always_comb begin
        if (!sh_cfg.vid_en)  mode_w = MODE_BLANK;
        else if (sh_cfg.gfx) mode_w = MODE_GFX;
        else                 mode_w = MODE_TEXT;
        disp_mode = mode_w;
        wide      = sh_cfg.half_dot & ~sh_cfg.shift[1];
    end

    assert_mode_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> disp_mode == (!$past(raw_cfg.vid_en) ? 2'b10 :
                                   ($past(raw_cfg.gfx) ? 2'b01 : 2'b00)));

    assert_wide_pick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> wide == ($past(raw_cfg.half_dot) &&
                              ($past(raw_cfg.shift) == 2'b00 || $past(raw_cfg.shift) == 2'b01)));

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |=> $stable(disp_mode) && $stable(wide));

endmodule

// File: rtl/ladr_row_seq.sv
module ladr_row_seq
    import ladr_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int START_W = 16,
    parameter int PITCH_W = 12,
    parameter int LINE_W  = 11,
    parameter int ROW_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_go,
    input  logic               line_step,
    input  logic [START_W-1:0] start,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [LINE_W-1:0]  split,
    input  logic [RPT_W-1:0]   cnt,
    input  logic [1:0]         mask,
    output logic [ADDR_W-1:0]  nxt_base,
    output logic [ROW_W-1:0]   nxt_row,
    output logic [LINE_W-1:0]  line_q,
    output logic               upd
);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [ROW_W-1:0]  row_q;
    logic [RPT_W-1:0]  rpt_q, nxt_rpt;
    logic [LINE_W-1:0] nxt_line;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and next scanline values
    always_comb begin
        state_d  = state_q;
        nxt_base = base_q;
        nxt_row  = row_q;
        nxt_rpt  = rpt_q;
        nxt_line = line_q;
        upd      = 1'b0;
        if (frame_go) begin
            state_d  = ST_SCAN;
            nxt_base = ADDR_W'({start, 2'b00});
            nxt_row  = '0;
            nxt_rpt  = cnt;
            nxt_line = '0;
            upd      = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SCAN: begin
                    if (line_step) begin
                        upd = 1'b1;
                        if (rpt_q == '0) begin
                            if ((row_q[1:0] & mask) == mask)
                                nxt_base = base_q + ADDR_W'(pitch);
                            nxt_row = row_q + 1'b1;
                            nxt_rpt = cnt;
                        end else begin
                            nxt_rpt = rpt_q - 1'b1;
                        end
                        if (line_q == split) nxt_base = '0;
                        nxt_line = line_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Scanline registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            row_q  <= '0;
            rpt_q  <= '0;
            line_q <= '0;
        end else if (upd) begin
            base_q <= nxt_base;
            row_q  <= nxt_row;
            rpt_q  <= nxt_rpt;
            line_q <= nxt_line;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_go) |=> line_q == '0 && row_q == '0);

    assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> line_q == '0 && row_q == '0 && state_q == ST_SCAN);

    assert_rpt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !frame_go) |-> rpt_q <= cnt);

    assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && line_step && !frame_go && rpt_q != '0) |=> $stable(row_q));

    assert_line_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && line_step && !frame_go) |=> line_q == $past(line_q) + 1'b1);

endmodule

// File: rtl/ladr_bit_subst.sv
module ladr_bit_subst #(
    parameter int ADDR_W = 18,
    parameter int ROW_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ROW_W-1:0]  row,
    input  logic              keep_lo,
    input  logic              keep_hi,
    input  logic              lo_sel,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        addr = base;
        if (!keep_lo) begin
            if (lo_sel) addr[15] = row[0];
            else        addr[14] = row[0];
        end
        // Row bit 1 is applied last so it wins on bit 15.
        if (!keep_hi) addr[15] = row[1];
    end

endmodule

// File: rtl/ladr_gen.sv
module ladr_gen
    import ladr_pkg::*;
#(
    parameter int START_W = 16,
    parameter int PITCH_W = 12,
    parameter int LINE_W  = 11,
    parameter int ROW_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_go,
    input  logic                 line_step,
    input  logic [START_W-1:0]   cfg_start,
    input  logic [PITCH_W-1:0]   cfg_pitch,
    input  logic [LINE_W-1:0]    cfg_split,
    input  logic [4:0]           cfg_scan_max,
    input  logic                 cfg_dbl,
    input  logic [1:0]           cfg_shift,
    input  logic                 cfg_keep_lo,
    input  logic                 cfg_keep_hi,
    input  logic                 cfg_lo_sel,
    input  logic                 cfg_vid_en,
    input  logic                 cfg_gfx,
    input  logic                 cfg_half_dot,
    output logic [START_W+1:0]   line_addr,
    output logic [LINE_W-1:0]    line_num,
    output logic [1:0]           disp_mode,
    output logic                 wide_out
);

    localparam int ADDR_W = START_W + 2;

    mode_cfg_t          raw_cfg, eff_cfg;
    logic [START_W-1:0] eff_start;
    logic [PITCH_W-1:0] eff_pitch;
    logic [LINE_W-1:0]  eff_split;
    logic [RPT_W-1:0]   eff_cnt;
    logic [1:0]         eff_mask;
    logic [ADDR_W-1:0]  nxt_base, nxt_addr, addr_q;
    logic [ROW_W-1:0]   nxt_row;
    logic               upd;

    always_comb begin
        raw_cfg.scan_max = cfg_scan_max;
        raw_cfg.dbl      = cfg_dbl;
        raw_cfg.shift    = cfg_shift;
        raw_cfg.keep_lo  = cfg_keep_lo;
        raw_cfg.keep_hi  = cfg_keep_hi;
        raw_cfg.lo_sel   = cfg_lo_sel;
        raw_cfg.vid_en   = cfg_vid_en;
        raw_cfg.gfx      = cfg_gfx;
        raw_cfg.half_dot = cfg_half_dot;
    end

    ladr_cfg_latch #(.START_W(START_W), .PITCH_W(PITCH_W), .LINE_W(LINE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_go  (frame_go),
        .raw_cfg   (raw_cfg),
        .raw_start (cfg_start),
        .raw_pitch (cfg_pitch),
        .raw_split (cfg_split),
        .eff_cfg   (eff_cfg),
        .eff_start (eff_start),
        .eff_pitch (eff_pitch),
        .eff_split (eff_split),
        .eff_cnt   (eff_cnt),
        .eff_mask  (eff_mask),
        .disp_mode (disp_mode),
        .wide      (wide_out)
    );

    ladr_row_seq #(.ADDR_W(ADDR_W), .START_W(START_W), .PITCH_W(PITCH_W),
                   .LINE_W(LINE_W), .ROW_W(ROW_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_go  (frame_go),
        .line_step (line_step),
        .start     (eff_start),
        .pitch     (eff_pitch),
        .split     (eff_split),
        .cnt       (eff_cnt),
        .mask      (eff_mask),
        .nxt_base  (nxt_base),
        .nxt_row   (nxt_row),
        .line_q    (line_num),
        .upd       (upd)
    );

    ladr_bit_subst #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_sub (
        .base    (nxt_base),
        .row     (nxt_row),
        .keep_lo (eff_cfg.keep_lo),
        .keep_hi (eff_cfg.keep_hi),
        .lo_sel  (eff_cfg.lo_sel),
        .addr    (nxt_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   addr_q <= '0;
        else if (upd) addr_q <= nxt_addr;
    end

    assign line_addr = addr_q;

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_go && !line_step) |=> $stable(line_addr) && $stable(line_num));

    assert_frame_line0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && cfg_keep_lo && cfg_keep_hi) |=> line_addr == {$past(cfg_start), 2'b00});

endmodule

// File: tb/test_ladr_gen.sv
module test_ladr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_go = 1'b0;
    logic        line_step = 1'b0;
    logic [15:0] cfg_start = '0;
    logic [11:0] cfg_pitch = '0;
    logic [10:0] cfg_split = 11'h7FF;
    logic [4:0]  cfg_scan_max = '0;
    logic        cfg_dbl = 1'b0;
    logic [1:0]  cfg_shift = 2'b10;
    logic        cfg_keep_lo = 1'b1;
    logic        cfg_keep_hi = 1'b1;
    logic        cfg_lo_sel = 1'b0;
    logic        cfg_vid_en = 1'b1;
    logic        cfg_gfx = 1'b1;
    logic        cfg_half_dot = 1'b0;
    logic [17:0] line_addr;
    logic [10:0] line_num;
    logic [1:0]  disp_mode;
    logic        wide_out;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state captured at each frame pulse
    logic [17:0] m_base;
    int m_row, m_rpt, m_cnt, m_line;
    int c_pitch, c_split;
    logic c_klo, c_khi, c_sel;
    logic [1:0] c_mode;
    logic c_wide;

    always #10 clk = ~clk;

    ladr_gen i_ladr_gen (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .line_step(line_step),
        .cfg_start(cfg_start), .cfg_pitch(cfg_pitch), .cfg_split(cfg_split),
        .cfg_scan_max(cfg_scan_max), .cfg_dbl(cfg_dbl), .cfg_shift(cfg_shift),
        .cfg_keep_lo(cfg_keep_lo), .cfg_keep_hi(cfg_keep_hi), .cfg_lo_sel(cfg_lo_sel),
        .cfg_vid_en(cfg_vid_en), .cfg_gfx(cfg_gfx), .cfg_half_dot(cfg_half_dot),
        .line_addr(line_addr), .line_num(line_num), .disp_mode(disp_mode),
        .wide_out(wide_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] m_addr();
        logic [17:0] a = m_base;
        if (!c_klo) begin
            if (c_sel) a[15] = m_row[0];
            else       a[14] = m_row[0];
        end
        if (!c_khi) a[15] = m_row[1];
        return a;
    endfunction

    task automatic frame_pulse(input string req);
        @(negedge clk);
        frame_go = 1'b1;
        if (cfg_shift == 2'b01) m_cnt = cfg_dbl;
        else                    m_cnt = ((cfg_scan_max + 1) << cfg_dbl) - 1;
        m_base  = {cfg_start, 2'b00};
        m_row   = 0;
        m_rpt   = m_cnt;
        m_line  = 0;
        c_pitch = cfg_pitch;
        c_split = cfg_split;
        c_klo   = cfg_keep_lo;
        c_khi   = cfg_keep_hi;
        c_sel   = cfg_lo_sel;
        c_mode  = !cfg_vid_en ? 2'b10 : (cfg_gfx ? 2'b01 : 2'b00);
        c_wide  = cfg_half_dot && (cfg_shift == 2'b00 || cfg_shift == 2'b01);
        @(negedge clk);
        frame_go = 1'b0;
        chk({req, " line0 addr"}, 32'(line_addr), 32'(m_addr()));
        chk({req, " line0 num"}, 32'(line_num), 32'd0);
        chk({req, " mode"}, 32'(disp_mode), 32'(c_mode));
        chk({req, " wide"}, 32'(wide_out), 32'(c_wide));
    endtask

    task automatic step_lines(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_step = 1'b1;
            if (m_rpt == 0) begin
                int mk = {~c_khi, ~c_klo};
                if ((m_row & mk) == mk) m_base = m_base + 18'(c_pitch);
                m_row++;
                m_rpt = m_cnt;
            end else begin
                m_rpt--;
            end
            if (m_line == c_split) m_base = '0;
            m_line++;
            @(negedge clk);
            line_step = 1'b0;
            chk({req, " addr"}, 32'(line_addr), 32'(m_addr()));
            chk({req, " num"}, 32'(line_num), 32'(m_line & 11'h7FF));
        end
    endtask

    task automatic t_reset_R1();
        chk("R1 reset addr", 32'(line_addr), 32'd0);
        chk("R1 reset num", 32'(line_num), 32'd0);
        chk("R1 reset mode", 32'(disp_mode), 32'h2);
        chk("R1 reset wide", 32'(wide_out), 32'd0);
        @(negedge clk); line_step = 1'b1;
        @(negedge clk); line_step = 1'b0;
        @(negedge clk);
        chk("R1 step before frame addr", 32'(line_addr), 32'd0);
        chk("R1 step before frame num", 32'(line_num), 32'd0);
    endtask

    task automatic t_plain_R2_R5();
        cfg_shift = 2'b10; cfg_scan_max = 0; cfg_dbl = 0; cfg_keep_lo = 1; cfg_keep_hi = 1;
        cfg_start = 16'h0100; cfg_pitch = 12'd80; cfg_split = 11'h7FF;
        frame_pulse("R2 plain");
        step_lines(6, "R5 plain advance");
        // Quiet cycles: outputs must hold
        repeat (4) @(negedge clk);
        chk("R12 hold addr", 32'(line_addr), 32'(m_addr()));
        chk("R12 hold num", 32'(line_num), 32'(m_line));
    endtask

    task automatic t_repeat_R3();
        cfg_shift = 2'b10; cfg_scan_max = 5'd2; cfg_dbl = 1; cfg_start = 16'h0020; cfg_pitch = 12'd160;
        frame_pulse("R3 repeat");
        step_lines(14, "R3 repeat x6");
        cfg_scan_max = 5'd31; cfg_dbl = 1;
        frame_pulse("R3 max repeat");
        step_lines(66, "R3 repeat x64");
    endtask

    task automatic t_mode1_R4();
        cfg_shift = 2'b01; cfg_scan_max = 5'd7; cfg_dbl = 1; cfg_start = 16'h0040; cfg_pitch = 12'd40;
        frame_pulse("R4 mode1 dbl");
        step_lines(6, "R4 mode1 dbl");
        cfg_dbl = 0;
        frame_pulse("R4 mode1 single");
        step_lines(4, "R4 mode1 single");
    endtask

    task automatic t_interleave_R6_R7();
        cfg_shift = 2'b10; cfg_scan_max = 0; cfg_dbl = 0; cfg_start = 16'h0010; cfg_pitch = 12'd80;
        cfg_keep_lo = 0; cfg_keep_hi = 0; cfg_lo_sel = 0;
        frame_pulse("R7 both rows");
        step_lines(9, "R5 R6 R7 four-way interleave");
        cfg_keep_lo = 0; cfg_keep_hi = 1; cfg_lo_sel = 1;
        frame_pulse("R6 row0 to bit15");
        step_lines(5, "R6 row0 to bit15");
        cfg_keep_lo = 0; cfg_keep_hi = 1; cfg_lo_sel = 0;
        frame_pulse("R6 row0 to bit14");
        step_lines(5, "R6 row0 to bit14");
        cfg_keep_lo = 1; cfg_keep_hi = 0;
        frame_pulse("R7 row1 only");
        step_lines(6, "R7 row1 only");
        cfg_keep_lo = 0; cfg_keep_hi = 0; cfg_lo_sel = 1;
        frame_pulse("R7 priority on bit15");
        step_lines(4, "R7 priority on bit15");
        cfg_keep_lo = 1; cfg_keep_hi = 1; cfg_lo_sel = 0;
    endtask

    task automatic t_split_R8();
        cfg_shift = 2'b10; cfg_scan_max = 0; cfg_dbl = 0; cfg_start = 16'h0010; cfg_pitch = 12'd40;
        cfg_split = 11'd3;
        frame_pulse("R8 split");
        step_lines(6, "R8 split");
        cfg_scan_max = 5'd1; cfg_split = 11'd2;
        frame_pulse("R8 split with repeat");
        step_lines(6, "R8 split with repeat");
        cfg_split = 11'h7FF; cfg_scan_max = 0;
    endtask

    task automatic t_modes_R9_R10();
        cfg_vid_en = 0; cfg_gfx = 1; cfg_shift = 2'b00; cfg_half_dot = 1;
        frame_pulse("R9 blank R10 shift0 wide");
        cfg_vid_en = 1; cfg_gfx = 0; cfg_shift = 2'b01; cfg_half_dot = 1;
        frame_pulse("R9 text R10 shift1 wide");
        cfg_vid_en = 1; cfg_gfx = 1; cfg_shift = 2'b10; cfg_half_dot = 1;
        frame_pulse("R9 graphics R10 shift2 narrow");
        cfg_shift = 2'b11; cfg_half_dot = 1;
        frame_pulse("R10 shift3 narrow");
        cfg_shift = 2'b00; cfg_half_dot = 0;
        frame_pulse("R10 no request");
        cfg_shift = 2'b10;
    endtask

    task automatic t_midframe_R11();
        cfg_shift = 2'b10; cfg_scan_max = 0; cfg_dbl = 0; cfg_start = 16'h0200; cfg_pitch = 12'd64;
        cfg_vid_en = 1; cfg_gfx = 1; cfg_half_dot = 0;
        frame_pulse("R11 base frame");
        step_lines(2, "R11 before change");
        cfg_start = 16'h3000; cfg_pitch = 12'd4; cfg_scan_max = 5'd3; cfg_keep_lo = 0;
        cfg_vid_en = 0; cfg_half_dot = 1; cfg_shift = 2'b00; cfg_split = 11'd0;
        step_lines(4, "R11 after change");
        chk("R11 mode held", 32'(disp_mode), 32'(c_mode));
        chk("R11 wide held", 32'(wide_out), 32'(c_wide));
        frame_pulse("R11 new frame takes change");
        step_lines(3, "R11 new frame");
        cfg_keep_lo = 1; cfg_vid_en = 1; cfg_half_dot = 0; cfg_shift = 2'b10; cfg_split = 11'h7FF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_plain_R2_R5();
        t_repeat_R3();
        t_mode1_R4();
        t_interleave_R6_R7();
        t_split_R8();
        t_modes_R9_R10();
        t_midframe_R11();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule